// File: doc/BRIEF.md
# Trigger Veto and Control Register

This block sits between an incoming event trigger line and the event readout logic of a data acquisition front end. A rising edge on the trigger line, accepted while the veto is clear, sets a veto latch. The latch blocks every later trigger until software releases it by writing a self-clearing clear bit into the 16-bit control output word. On each accepted trigger the 16-bit input word is captured, and a one-cycle strobe marks it for the event record.

Ten of the output bits are looped back into the input word, replacing the pin values at those positions. The captured word therefore records the control state, including the 5-bit trigger-select field, that was in force when the trigger arrived. After an event has been handled, the trigger-select field can be reloaded on its own for the next event, without rewriting the rest of the output word. The trigger line and the other input pins pass through a two-stage synchroniser. The trigger line then goes through an edge detector.

Top module: `trig_veto_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_word, veto, event_valid and event_word are all zero.
- R2: A 0-to-1 change on pin_in[15] while veto is 0 makes veto 1 and event_valid 1 after the third rising clock edge following the change. event_valid stays high for exactly one cycle.
- R3: While veto is 1, further rising edges on pin_in[15] produce no event_valid, and event_word stays unchanged.
- R4: A write with wr_en loads wr_data into out_word. Bit 0 of out_word, the clear bit, is high for one cycle only and then returns to 0, while bits 15..1 keep the written value.
- R5: veto falls only on the clock edge that follows a cycle in which out_word[0] is 1.
- R6: event_word holds bits 10..1 of out_word as they were at the capture edge, the synchronised pin_in values at bits 0 and 14..11, and a 1 at bit 15.
- R7: A pulse on sel_wr_en replaces bits 5..1 of out_word with sel_data, leaves bits 15..6 unchanged, and drops bit 0. When wr_en and sel_wr_en are both high in the same cycle, bits 5..1 take sel_data and the other bits take wr_data.
- R8: A trigger line held high produces only one event. After the veto is released, the line must fall and rise again before another event is accepted.
- R9: If a trigger is accepted in the same cycle as the clear bit is high, the veto is set and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw input pins. Bit 15 is the trigger line |
| wr_en | input | 1 | Write strobe for the full output word |
| wr_data | input | 16 | Output word value to write |
| sel_wr_en | input | 1 | Reload strobe for the trigger-select field |
| sel_data | input | 5 | New trigger-select value |
| out_word | output | 16 | Control output word. Bit 0 is the clear bit, bits 5..1 are the select field |
| veto | output | 1 | Veto latch state |
| event_valid | output | 1 | One-cycle strobe when event_word is captured |
| event_word | output | 16 | Input word captured at the last accepted trigger |

## Verification
The bench holds the trigger high across a veto release. A design that fires on level instead of on an edge would then log a second, phantom event. It also times a clear pulse so that it coincides with a new trigger edge: if clear took priority over set in the latch, the veto would drop and the event would be left unprotected. The captured word is checked against pin patterns that differ from the output bits at the looped-back positions, so reading the pins at those positions gives a wrong word. A same-cycle full write and select reload shows whether the select field is given the correct priority.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int DIO_W = 16;

  typedef logic [DIO_W-1:0] dio_word_t;

  // Mask of W ones starting at bit LSB.
  function automatic dio_word_t field_mask(input int lsb, input int w);
    dio_word_t m;
    m = '0;
    for (int i = 0; i < DIO_W; i++) begin
      if (i >= lsb && i < lsb + w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Input word as seen by the capture logic: loop-back positions come
  // from the output register, the rest from the synchronised pins.
  function automatic dio_word_t merge_loopback(input dio_word_t pins,
                                               input dio_word_t outs,
                                               input dio_word_t lb_mask);
    return (pins & ~lb_mask) | (outs & lb_mask);
  endfunction

  // Next output word: clear bit self-clears, full write, then select reload.
  function automatic dio_word_t next_ctrl_word(input dio_word_t cur,
                                               input logic      wr,
                                               input dio_word_t wdata,
                                               input logic      sel_wr,
                                               input dio_word_t sel_shifted,
                                               input dio_word_t sel_mask,
                                               input int        clr_bit);
    dio_word_t n;
    n = cur;
    n[clr_bit] = 1'b0;
    if (wr) n = wdata;
    if (sel_wr) n = (n & ~sel_mask) | (sel_shifted & sel_mask);
    return n;
  endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge
  import trig_pkg::*;
#(
  parameter int STAGES   = 2,
  parameter int EDGE_BIT = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dio_word_t pins_async,
  output dio_word_t pins_sync,
  output logic      rise
);

  logic [STAGES-1:0][DIO_W-1:0] stage_q;
  logic                         edge_prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q[0] <= pins_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], pins_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= 1'b0;
    else        edge_prev_q <= stage_q[STAGES-1][EDGE_BIT];
  end

  assign pins_sync = stage_q[STAGES-1];
  assign rise      = stage_q[STAGES-1][EDGE_BIT] & ~edge_prev_q;

endmodule

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg
  import trig_pkg::*;
#(
  parameter int CLR_BIT = 0,
  parameter int SEL_LSB = 1,
  parameter int SEL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  dio_word_t        wr_data,
  input  logic             sel_wr_en,
  input  logic [SEL_W-1:0] sel_data,
  output dio_word_t        out_q,
  output logic             clr_pulse
);

  localparam dio_word_t SEL_MASK = field_mask(SEL_LSB, SEL_W);

  dio_word_t sel_shifted;
  dio_word_t out_d;

  always_comb begin
    sel_shifted = dio_word_t'(sel_data) << SEL_LSB;
    out_d = next_ctrl_word(out_q, wr_en, wr_data, sel_wr_en,
                           sel_shifted, SEL_MASK, CLR_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign clr_pulse = out_q[CLR_BIT];

endmodule

// File: rtl/trig_veto_latch.sv
module trig_veto_latch
  import trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      clr_pulse,
  input  dio_word_t cap_word,
  output logic      accept,
  output logic      veto,
  output logic      event_valid,
  output dio_word_t event_word
);

  assign accept = rise & ~veto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      veto        <= 1'b0;
      event_valid <= 1'b0;
      event_word  <= '0;
    end else begin
      // set has priority over release
      if (accept)         veto <= 1'b1;
      else if (clr_pulse) veto <= 1'b0;
      event_valid <= accept;
      if (accept) event_word <= cap_word;
    end
  end

endmodule

// File: rtl/trig_veto_ctrl.sv
module trig_veto_ctrl
  import trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_BIT    = 15,
  parameter int CLR_BIT     = 0,
  parameter int SEL_LSB     = 1,
  parameter int SEL_W       = 5,
  parameter int LOOP_LSB    = 1,
  parameter int LOOP_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      pin_in,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             sel_wr_en,
  input  logic [SEL_W-1:0] sel_data,
  output logic [15:0]      out_word,
  output logic             veto,
  output logic             event_valid,
  output logic [15:0]      event_word
);

  localparam dio_word_t LOOP_MASK = field_mask(LOOP_LSB, LOOP_W);

  // Named internal events, visible to the bound checker.
  dio_word_t pins_sync;
  dio_word_t cap_word;
  logic      trig_rise;
  logic      trig_accept;
  logic      clr_pulse;

  trig_sync_edge #(
    .STAGES   (SYNC_STAGES),
    .EDGE_BIT (TRIG_BIT)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_async (pin_in),
    .pins_sync  (pins_sync),
    .rise       (trig_rise)
  );

  trig_ctrl_reg #(
    .CLR_BIT (CLR_BIT),
    .SEL_LSB (SEL_LSB),
    .SEL_W   (SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sel_wr_en (sel_wr_en),
    .sel_data  (sel_data),
    .out_q     (out_word),
    .clr_pulse (clr_pulse)
  );

  assign cap_word = merge_loopback(pins_sync, out_word, LOOP_MASK);

  trig_veto_latch u_veto (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (trig_rise),
    .clr_pulse   (clr_pulse),
    .cap_word    (cap_word),
    .accept      (trig_accept),
    .veto        (veto),
    .event_valid (event_valid),
    .event_word  (event_word)
  );

endmodule

// File: rtl/trig_veto_ctrl_chk.sv
module trig_veto_ctrl_chk #(
  parameter int TRIG_BIT = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic        veto,
  input logic        event_valid,
  input logic [15:0] event_word,
  input logic        trig_rise,
  input logic        trig_accept,
  input logic        clr_pulse
);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    event_valid |=> !event_valid);

  assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> (veto && event_valid));

  assert_vetoed_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (veto && $past(veto)) |-> !event_valid);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !event_valid |-> $stable(event_word));

  assert_release_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(veto) |-> $past(clr_pulse));

  assert_trig_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    event_valid |-> event_word[TRIG_BIT]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && clr_pulse && !veto) |=> veto);

endmodule

bind trig_veto_ctrl trig_veto_ctrl_chk #(.TRIG_BIT(TRIG_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .veto        (veto),
  .event_valid (event_valid),
  .event_word  (event_word),
  .trig_rise   (trig_rise),
  .trig_accept (trig_accept),
  .clr_pulse   (clr_pulse)
);

// File: tb/tb_trig_veto_ctrl.sv
module tb_trig_veto_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sel_wr_en = 1'b0;
  logic [4:0]  sel_data = '0;
  logic [15:0] out_word;
  logic        veto;
  logic        event_valid;
  logic [15:0] event_word;

  int nchecks = 0;
  int nfails  = 0;
  logic [15:0] exp_q[$];
  logic [15:0] saved;

  always #5 clk = ~clk;

  trig_veto_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .wr_data(wr_data),
    .sel_wr_en(sel_wr_en), .sel_data(sel_data), .out_word(out_word),
    .veto(veto), .event_valid(event_valid), .event_word(event_word)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected capture: bits 10..1 from the output word, 15 set, rest from pins.
  function automatic logic [15:0] exp_word(input logic [15:0] o, input logic [15:0] p);
    return (p & 16'hF801) | (o & 16'h07FE) | 16'h8000;
  endfunction

  // Monitor: pop and compare each captured word.
  always @(negedge clk) begin
    if (rst_n && event_valid) begin
      if (exp_q.size() == 0)
        check(1'b0, "R3 unexpected event", event_word, 16'h0000);
      else begin
        saved = exp_q.pop_front();
        check(event_word === saved, "R6 scoreboard word", event_word, saved);
      end
    end
  end

  task automatic do_write(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: raise trigger, push expected item, time the strobe.
  task automatic trig_accept_seq();
    @(negedge clk); pins[15] = 1'b1; exp_q.push_back(exp_word(out_word, pins));
    @(negedge clk);
    @(negedge clk);
    check(!event_valid, "R2 no early strobe", {15'd0, event_valid}, 16'd0);
    @(negedge clk);
    check(event_valid && veto, "R2 strobe and veto", {14'd0, veto, event_valid}, 16'd3);
    @(negedge clk);
    check(!event_valid, "R2 single-cycle strobe", {15'd0, event_valid}, 16'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_word == 0 && !veto && !event_valid && event_word == 0,
          "R1 reset state", out_word | event_word, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_word == 0 && !veto && !event_valid && event_word == 0,
          "R1 after release", out_word | event_word, 16'h0000);

    // R6 first pattern: pins at loop-back positions differ from out_word
    pins = 16'h5A5B;
    do_write(16'h0154);
    check(out_word == 16'h0154, "R4 write value", out_word, 16'h0154);
    trig_accept_seq();
    check(event_word == 16'hD955, "R6 capture pattern 1", event_word, 16'hD955);

    // R3: re-trigger while vetoed
    saved = event_word;
    @(negedge clk); pins[15] = 1'b0;
    repeat (4) @(negedge clk);
    pins[15] = 1'b1;
    repeat (6) @(negedge clk);
    check(veto == 1'b1, "R3 veto held", {15'd0, veto}, 16'd1);
    check(event_word == saved, "R3 word unchanged", event_word, saved);

    // R4/R5/R8: clear with trigger still high
    do_write(16'h0155);
    check(out_word == 16'h0155 && veto, "R4 clear bit high", out_word, 16'h0155);
    @(negedge clk);
    check(out_word == 16'h0154, "R4 clear bit self-clears", out_word, 16'h0154);
    check(!veto, "R5 veto released", {15'd0, veto}, 16'd0);
    repeat (6) @(negedge clk);
    check(!veto, "R8 held level no retrigger", {15'd0, veto}, 16'd0);

    // R7: select reload alone, then together with a full write
    @(negedge clk); sel_wr_en = 1'b1; sel_data = 5'b10011;
    @(negedge clk); sel_wr_en = 1'b0;
    check(out_word == 16'h0166, "R7 select reload", out_word, 16'h0166);
    @(negedge clk); sel_wr_en = 1'b1; sel_data = 5'b00000; wr_en = 1'b1; wr_data = 16'h0FFE;
    @(negedge clk); sel_wr_en = 1'b0; wr_en = 1'b0;
    check(out_word == 16'h0FC0, "R7 reload beats write", out_word, 16'h0FC0);

    // R8 fall and rise again, R6 second pattern
    pins = 16'h2403;
    repeat (3) @(negedge clk);
    trig_accept_seq();
    check(event_word == 16'hA7C1, "R6 capture pattern 2", event_word, 16'hA7C1);

    // R9: clear pulse coincides with trigger rise
    do_write(16'h0FC1);
    @(negedge clk);
    check(!veto, "R5 veto released again", {15'd0, veto}, 16'd0);
    pins[15] = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk); pins[15] = 1'b1; exp_q.push_back(exp_word(16'h0FC0, pins));
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0FC1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    check(veto && event_valid, "R9 set wins", {14'd0, veto, event_valid}, 16'd3);
    @(negedge clk);
    check(veto, "R9 veto stays", {15'd0, veto}, 16'd1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all events seen", 16'(exp_q.size()), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nfails++;
    $display("FAIL watchdog R2 actual=%h expected=%h", 16'h0001, 16'h0000);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end

endmodule